// File: doc/BRIEF.md
# Sliding 3x3 Window Sequencer

This block takes a 5x5 tile of 8-bit pixels in one load cycle. It then presents every 3x3 sub-square of that tile, one per clock. The tile has nine such windows, and they overlap. The block applies no arithmetic to the pixel values. It only selects which stored bytes appear on the output.

A producer pulses the load strobe with a tile on the wide input while the block is idle. On the next cycle the first window appears with valid high. The window origin then moves by one position each cycle. The last flag marks the ninth window. After that the block is idle and accepts a new tile.

The pixel width, tile side and window side are parameters. The defaults are 8, 5 and 3.

Top module: `win_seq`

## Requirements
- R1: While reset is held low, `win_valid_o` is 0, `win_last_o` is 0 and `win_idx_o` is 0.
- R2: When `load_i` is high at a rising edge while the block is idle, the tile is captured. Starting with the next cycle, `win_valid_o` is 1 and `win_idx_o` is 0. Without a load, `win_valid_o` stays 0.
- R3: After a load is accepted, `win_valid_o` stays high for exactly nine consecutive cycles.
- R4: Window k (k = 0..8) is given in the k-th valid cycle, and `win_idx_o` equals k. Its top-left origin is row k/3, column k%3, so origins go in row-major order: (0,0), (0,1), (0,2), (1,0) and so on to (2,2).
- R5: Tile pixel (r,c) sits at `tile_i[8*(5r+c) +: 8]`. Window pixel (i,j) sits at `win_o[8*(3i+j) +: 8]`. For window k, window pixel (i,j) equals tile pixel (k/3+i, k%3+j), unmodified.
- R6: `win_last_o` is 1 only in the cycle that carries window 8. In the following cycle `win_valid_o` is 0.
- R7: A load strobe that arrives while windows are being output, including in the last-window cycle, is ignored. The captured tile, the window order and the window data are unchanged.
- R8: A load held high from the last-window cycle into the first idle cycle is accepted at that idle edge. Window 0 of the new tile follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Tile load strobe; honoured only when idle |
| tile_i | input | 200 | 25 pixels, pixel (r,c) at bits 8*(5r+c) upward |
| win_valid_o | output | 1 | A window is present on `win_o` |
| win_o | output | 72 | 9 pixels, pixel (i,j) at bits 8*(3i+j) upward |
| win_idx_o | output | 4 | Index k of the current window, 0..8 |
| win_last_o | output | 1 | High with window 8 |

## Verification
The hardest case to reach from the ports is a load strobe that coincides with the sequence boundary. It can land on the last-window cycle, where it must be ignored, and then stay high into the first idle cycle, where it must be taken. The bench reaches this by keeping the strobe high, with a second tile, from the ninth window onward. It then checks that the idle gap is exactly one cycle and that the second tile's windows follow.

Other sequences drive the strobe with an inverted tile in the middle of a walk. These check that every window still comes from the original tile. A sweep over two dozen computed tiles compares every pixel of every window against indices derived from the requirements.

// File: rtl/win_seq_pkg.sv
`timescale 1ns/1ps
package win_seq_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WALK = 1'b1
   } walk_state_e;

   // Width needed to hold values 0..n-1, never below one bit.
   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/win_tile_store.sv
`timescale 1ns/1ps
module win_tile_store #(
   parameter int BITS = 200
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            capture_i,
   input  logic [BITS-1:0] tile_i,
   output logic [BITS-1:0] tile_o
);

   logic [BITS-1:0] tile_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tile_q <= '0;
      end else if (capture_i) begin
         tile_q <= tile_i;
      end
   end

   assign tile_o = tile_q;

endmodule

// File: rtl/win_origin_walker.sv
`timescale 1ns/1ps
module win_origin_walker
   import win_seq_pkg::*;
#(
   parameter int STEPS = 3,
   parameter int CW    = 2,
   parameter int IDX_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             accept_o,
   output logic             busy_o,
   output logic [CW-1:0]    row_o,
   output logic [CW-1:0]    col_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             last_o
);

   localparam logic [CW-1:0] EDGE = CW'(STEPS - 1);

   walk_state_e      state_q;
   logic [CW-1:0]    row_q, col_q;
   logic [IDX_W-1:0] idx_q;
   logic             at_row_end;

   assign busy_o     = (state_q == ST_WALK);
   assign accept_o   = start_i && !busy_o;
   assign at_row_end = (col_q == EDGE);
   assign last_o     = busy_o && at_row_end && (row_q == EDGE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         col_q   <= '0;
         idx_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_WALK;
                  row_q   <= '0;
                  col_q   <= '0;
                  idx_q   <= '0;
               end
            end
            ST_WALK: begin
               if (last_o) begin
                  state_q <= ST_IDLE;
                  row_q   <= '0;
                  col_q   <= '0;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
                  if (at_row_end) begin
                     col_q <= '0;
                     row_q <= row_q + CW'(1);
                  end else begin
                     col_q <= col_q + CW'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign row_o = row_q;
   assign col_o = col_q;
   assign idx_o = idx_q;

endmodule

// File: rtl/win_window_mux.sv
`timescale 1ns/1ps
module win_window_mux
   import win_seq_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int TILE  = 5,
   parameter int WIN   = 3,
   parameter int CW    = 2
) (
   input  logic [TILE*TILE*PIX_W-1:0] tile_i,
   input  logic [CW-1:0]              row_i,
   input  logic [CW-1:0]              col_i,
   output logic [WIN*WIN*PIX_W-1:0]   win_o
);

   localparam int ROW_BITS = TILE * PIX_W;
   localparam int RIX_W    = bits_for(TILE);

   logic [ROW_BITS-1:0] band [WIN];

   // Row stage picks WIN tile rows, column stage picks WIN pixels from each.
   for (genvar gi = 0; gi < WIN; gi++) begin : g_band
      logic [RIX_W-1:0] rsel;
      assign rsel     = RIX_W'(row_i) + RIX_W'(gi);
      assign band[gi] = tile_i[int'(rsel)*ROW_BITS +: ROW_BITS];
      for (genvar gj = 0; gj < WIN; gj++) begin : g_pix
         logic [RIX_W-1:0] csel;
         assign csel = RIX_W'(col_i) + RIX_W'(gj);
         assign win_o[(gi*WIN+gj)*PIX_W +: PIX_W] =
            band[gi][int'(csel)*PIX_W +: PIX_W];
      end
   end

endmodule

// File: rtl/win_seq.sv
`timescale 1ns/1ps
module win_seq
   import win_seq_pkg::*;
#(
   parameter  int PIX_W     = 8,
   parameter  int TILE      = 5,
   parameter  int WIN       = 3,
   localparam int STEPS     = TILE - WIN + 1,
   localparam int NUM_WIN   = STEPS * STEPS,
   localparam int TILE_BITS = TILE * TILE * PIX_W,
   localparam int WIN_BITS  = WIN * WIN * PIX_W,
   localparam int IDX_W     = bits_for(NUM_WIN),
   localparam int CW        = bits_for(STEPS)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 load_i,
   input  logic [TILE_BITS-1:0] tile_i,
   output logic                 win_valid_o,
   output logic [WIN_BITS-1:0]  win_o,
   output logic [IDX_W-1:0]     win_idx_o,
   output logic                 win_last_o
);

   if (PIX_W < 1) begin : g_bad_pix
      $error("win_seq: PIX_W must be at least 1");
   end
   if (WIN < 1 || WIN > TILE) begin : g_bad_win
      $error("win_seq: WIN must lie in 1..TILE");
   end

   logic                 accept;
   logic                 busy;
   logic [CW-1:0]        row, col;
   logic [TILE_BITS-1:0] tile_q;

   win_origin_walker #(
      .STEPS(STEPS),
      .CW   (CW),
      .IDX_W(IDX_W)
   ) u_walk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (load_i),
      .accept_o(accept),
      .busy_o  (busy),
      .row_o   (row),
      .col_o   (col),
      .idx_o   (win_idx_o),
      .last_o  (win_last_o)
   );

   win_tile_store #(
      .BITS(TILE_BITS)
   ) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .capture_i(accept),
      .tile_i   (tile_i),
      .tile_o   (tile_q)
   );

   win_window_mux #(
      .PIX_W(PIX_W),
      .TILE (TILE),
      .WIN  (WIN),
      .CW   (CW)
   ) u_mux (
      .tile_i(tile_q),
      .row_i (row),
      .col_i (col),
      .win_o (win_o)
   );

   assign win_valid_o = busy;

endmodule

// File: rtl/win_seq_chk.sv
`timescale 1ns/1ps
module win_seq_chk #(
   parameter int NUM_WIN   = 9,
   parameter int IDX_W     = 4,
   parameter int TILE_BITS = 200
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 load_i,
   input logic                 win_valid_o,
   input logic                 win_last_o,
   input logic [IDX_W-1:0]     win_idx_o,
   input logic [TILE_BITS-1:0] tile_q
);

   p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!win_valid_o && load_i) |=> (win_valid_o && win_idx_o == '0));

   p_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_valid_o && !win_last_o) |=> win_valid_o);

   p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_valid_o && !win_last_o) |=> (win_idx_o == $past(win_idx_o) + IDX_W'(1)));

   p_last_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_last_o |-> (win_valid_o && win_idx_o == IDX_W'(NUM_WIN - 1)));

   p_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_last_o |=> !win_valid_o);

   p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      win_valid_o |=> $stable(tile_q));

endmodule

bind win_seq win_seq_chk #(
   .NUM_WIN  (NUM_WIN),
   .IDX_W    (IDX_W),
   .TILE_BITS(TILE_BITS)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .load_i     (load_i),
   .win_valid_o(win_valid_o),
   .win_last_o (win_last_o),
   .win_idx_o  (win_idx_o),
   .tile_q     (tile_q)
);

// File: tb/tb_win_seq.sv
`timescale 1ns/1ps
module tb_win_seq;

   localparam int TB = 200;
   localparam int WB = 72;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          load;
   logic [TB-1:0] tile;
   logic          valid, last;
   logic [WB-1:0] win;
   logic [3:0]    idx;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   win_seq dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .load_i     (load),
      .tile_i     (tile),
      .win_valid_o(valid),
      .win_o      (win),
      .win_idx_o  (idx),
      .win_last_o (last)
   );

   task automatic check(input bit ok, input string req,
                        input logic [TB-1:0] act, input logic [TB-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [TB-1:0] mk_tile(input int seed);
      logic [TB-1:0] t;
      for (int p = 0; p < 25; p++) t[p*8 +: 8] = 8'(seed*53 + p*29 + p*p + (seed >> 2));
      return t;
   endfunction

   // Expected window k, computed from the origin rule and the bit layouts of R5.
   function automatic logic [WB-1:0] exp_win(input logic [TB-1:0] t, input int k);
      logic [WB-1:0] w;
      for (int i = 0; i < 3; i++)
         for (int j = 0; j < 3; j++)
            w[(3*i+j)*8 +: 8] = t[((k/3 + i)*5 + (k%3) + j)*8 +: 8];
      return w;
   endfunction

   // Entered at the falling edge just after the accepting edge.
   // mode 0: quiet; 1: junk load mid-walk (R7); 2: next tile loaded from the last cycle (R8).
   task automatic run_windows(input logic [TB-1:0] t, input int mode, input logic [TB-1:0] nxt);
      for (int k = 0; k < 9; k++) begin
         check(valid === 1'b1, "R3 valid run", TB'(valid), TB'(1));
         check(idx === 4'(k), "R4 index order", TB'(idx), TB'(k));
         check(last === (k == 8), "R6 last flag", TB'(last), TB'(k == 8));
         check(win === exp_win(t, k), (mode == 1 && k >= 3) ? "R7 window after ignored load" : "R5 window data",
               TB'(win), TB'(exp_win(t, k)));
         if (mode == 1 && k >= 2 && k <= 5) begin
            load = 1'b1; tile = ~t;
         end else if (mode == 2 && k == 8) begin
            load = 1'b1; tile = nxt;
         end else begin
            load = 1'b0;
         end
         @(negedge clk);
      end
      check(valid === 1'b0, "R6 idle after last", TB'(valid), TB'(0));
      check(last === 1'b0, "R6 last cleared", TB'(last), TB'(0));
   endtask

   initial begin
      rst_n = 1'b0; load = 1'b0; tile = '0;
      repeat (3) @(negedge clk);
      check(valid === 1'b0, "R1 reset valid", TB'(valid), TB'(0));
      check(last === 1'b0, "R1 reset last", TB'(last), TB'(0));
      check(idx === 4'd0, "R1 reset index", TB'(idx), TB'(0));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(valid === 1'b0, "R2 no load stays idle", TB'(valid), TB'(0));

      for (int s = 0; s < 26; s++) begin
         logic [TB-1:0] a, b;
         a = (s == 24) ? '0 : (s == 25) ? '1 : mk_tile(s);
         b = mk_tile(s + 100);
         load = 1'b1; tile = a;
         @(negedge clk);
         load = 1'b0;
         check(valid === 1'b1 && idx === 4'd0, "R2 start after load", TB'({valid, idx}), TB'({1'b1, 4'd0}));
         run_windows(a, s % 3, b);
         if (s % 3 == 2) begin
            // R8: strobe still high at the idle edge, new tile starts now.
            @(negedge clk);
            load = 1'b0;
            check(valid === 1'b1 && idx === 4'd0, "R8 chained start", TB'({valid, idx}), TB'({1'b1, 4'd0}));
            run_windows(b, 0, b);
         end
         @(negedge clk);
         check(valid === 1'b0, "R2 idle between tiles", TB'(valid), TB'(0));
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule